// File: doc/BRIEF.md
# Strided Vector Memory Sequencer

This block executes one vector load or vector store command as a series of single-element memory accesses. A command gives a start address, an element size, an addressing mode, a register-supplied byte stride, a zero-extension flag, an element count and a vector register number. The sequencer visits elements from index 0 upwards. For each one it issues a memory request under a valid/ready handshake and computes the next address by adding the step for the command.

On a load it waits for the single response it has asked for. It then sign- or zero-extends the returned bits to the element width and writes them into the chosen register at the current element slot. On a store it reads that register slot through a combinational read port and sends the trimmed data with the request. A one-cycle done pulse closes every accepted command. A doubleword command issued while wide integer mode is off is refused with a one-cycle illegal pulse.

Top module: `vseq_mem_sequencer`

## Requirements
- R1: The first request of a command carries `cmd_base`. Each later request adds the step to the previous address. The sum wraps modulo 2^64.
- R2: With `cmd_strided` low, the step is the element size in bytes. `cmd_size` codes 0, 1, 2 and 3 give 1, 2, 4 and 8 bytes.
- R3: With `cmd_strided` high, the step is `cmd_stride` read as a byte distance. A stride of zero touches the same address for every element.
- R4: Elements are handled in order from 0 to the effective length minus one. The effective length is `cmd_vlen` limited to NUM_ELEM. A length of 0 makes no request, and done follows in the cycle after acceptance.
- R5: A load writes each response to register `cmd_reg`, slot i, in the cycle the response arrives. For codes 0, 1 and 2 the data is sign-extended from bit 7, 15 or 31, or zero-extended when `cmd_zext` is high. For code 3 all 64 bits are written whatever `cmd_zext` is.
- R6: A store reads slot i of register `cmd_reg`. It sends the low 8, 16, 32 or 64 bits of that slot unchanged, with the upper bits zero, and `mem_req_write` high.
- R7: When `cmd_size` is 3 and `wide_int_en` is low, the command is refused. `illegal` pulses in the next cycle, and `busy` stays low and no request is made.
- R8: At most one request is outstanding. While `mem_req_ready` is low, a pending request holds its valid, address and direction. After a load handshake, no new request appears until the response has been taken.
- R9: A command is accepted only when `busy` is low, and `cmd_valid` while busy is ignored. `busy` is high from the cycle after acceptance through the single done cycle, and it is low again afterwards.
- R10: `mem_resp_valid` has no effect unless a load is waiting for its response. No register write and no change to the element sequence follow from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_strided | input | 1 | 1 = register stride, 0 = size stride |
| cmd_size | input | 2 | Element size code 0..3 |
| cmd_zext | input | 1 | Zero-extend loaded elements |
| cmd_base | input | 64 | Address of element 0 |
| cmd_stride | input | 64 | Byte stride for strided mode |
| cmd_vlen | input | VL_W | Requested element count |
| cmd_reg | input | REG_W | Vector register number |
| wide_int_en | input | 1 | Doubleword integer accesses allowed |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end of command |
| illegal | output | 1 | One-cycle refusal pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | Request is a store |
| mem_req_size | output | 2 | Access size code |
| mem_req_addr | output | 64 | Access byte address |
| mem_req_wdata | output | 64 | Store data |
| mem_resp_valid | input | 1 | Load data returned |
| mem_resp_data | input | 64 | Returned load data |
| vreg_rd_reg | output | REG_W | Store source register |
| vreg_rd_elem | output | IDX_W | Store source slot |
| vreg_rd_data | input | 64 | Slot contents |
| vreg_wr_en | output | 1 | Register slot write |
| vreg_wr_reg | output | REG_W | Destination register |
| vreg_wr_elem | output | IDX_W | Destination slot |
| vreg_wr_data | output | 64 | Extended load data |

## Verification
The bench builds the sequencer with NUM_ELEM = 8 and NUM_REGS = 32. A full-length vector is therefore short, and the bench runs it many times. A requested length of 15 is above the limit, which brings the clamping of the element count within reach. All 32 register numbers can be picked at random. Start addresses near the top of the 64-bit space, together with negative and zero strides, exercise the wraparound and same-address cases.

// File: rtl/vseq_pkg.sv
`timescale 1ns/1ps
package vseq_pkg;

    parameter int unsigned XLEN = 64;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } esize_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_e;

    // bytes covered by one element of the given size
    function automatic logic [XLEN-1:0] size_bytes(esize_e sz);
        return XLEN'(1) << sz;
    endfunction

    // widen returned load bits to a full element
    function automatic logic [XLEN-1:0] load_extend(esize_e sz, logic zext,
                                                    logic [XLEN-1:0] d);
        logic [XLEN-1:0] r;
        case (sz)
            SZ_B:    r = {{(XLEN-8){d[7] & ~zext}}, d[7:0]};
            SZ_H:    r = {{(XLEN-16){d[15] & ~zext}}, d[15:0]};
            SZ_W:    r = {{(XLEN-32){d[31] & ~zext}}, d[31:0]};
            default: r = d;
        endcase
        return r;
    endfunction

    // keep only the bytes a store of this size transfers
    function automatic logic [XLEN-1:0] store_trim(esize_e sz, logic [XLEN-1:0] d);
        logic [XLEN-1:0] r;
        case (sz)
            SZ_B:    r = {{(XLEN-8){1'b0}}, d[7:0]};
            SZ_H:    r = {{(XLEN-16){1'b0}}, d[15:0]};
            SZ_W:    r = {{(XLEN-32){1'b0}}, d[31:0]};
            default: r = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vseq_addr_gen.sv
`timescale 1ns/1ps
module vseq_addr_gen
    import vseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] step,
    input  logic            advance,
    output logic [XLEN-1:0] addr
);
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            step_q <= '0;
        end else if (load) begin
            addr_q <= base;
            step_q <= step;
        end else if (advance) begin
            addr_q <= addr_q + step_q;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/vseq_data_fmt.sv
`timescale 1ns/1ps
module vseq_data_fmt
    import vseq_pkg::*;
(
    input  esize_e          size,
    input  logic            zext,
    input  logic [XLEN-1:0] resp_data,
    input  logic [XLEN-1:0] slot_data,
    output logic [XLEN-1:0] load_data,
    output logic [XLEN-1:0] store_data
);
    assign load_data  = load_extend(size, zext, resp_data);
    assign store_data = store_trim(size, slot_data);
endmodule

// File: rtl/vseq_ctrl.sv
`timescale 1ns/1ps
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter  int unsigned NUM_ELEM = 32,
    localparam int unsigned IDX_W    = $clog2(NUM_ELEM),
    localparam int unsigned VL_W     = $clog2(NUM_ELEM + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_store,
    input  logic [1:0]       cmd_size,
    input  logic [VL_W-1:0]  cmd_vlen,
    input  logic             wide_int_en,
    input  logic             req_ready,
    input  logic             resp_valid,
    output logic             accept,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic             req_valid,
    output logic             resp_take,
    output logic             advance,
    output logic             store_mode,
    output logic [IDX_W-1:0] idx
);
    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, last_q;
    logic             store_q, illegal_q;
    logic             legal, is_last, idle;
    logic [VL_W-1:0]  vlen_eff;

    assign idle     = (state_q == ST_IDLE);
    assign legal    = !((esize_e'(cmd_size) == SZ_D) && !wide_int_en);
    assign vlen_eff = (cmd_vlen > VL_W'(NUM_ELEM)) ? VL_W'(NUM_ELEM) : cmd_vlen;
    assign accept   = cmd_valid && idle && legal;
    assign is_last  = (idx_q == last_q);

    always_comb begin
        state_d   = state_q;
        req_valid = 1'b0;
        resp_take = 1'b0;
        advance   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept)
                    state_d = (vlen_eff == '0) ? ST_FINISH : ST_ISSUE;
            end
            ST_ISSUE: begin
                req_valid = 1'b1;
                if (req_ready) begin
                    if (store_q) begin
                        advance = 1'b1;
                        state_d = is_last ? ST_FINISH : ST_ISSUE;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (resp_valid) begin
                    resp_take = 1'b1;
                    advance   = 1'b1;
                    state_d   = is_last ? ST_FINISH : ST_ISSUE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            last_q    <= '0;
            store_q   <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            illegal_q <= cmd_valid && idle && !legal;
            if (accept) begin
                idx_q   <= '0;
                last_q  <= IDX_W'(vlen_eff - VL_W'(1));
                store_q <= cmd_store;
            end else if (advance && !is_last) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    assign busy       = !idle;
    assign done       = (state_q == ST_FINISH);
    assign illegal    = illegal_q;
    assign store_mode = store_q;
    assign idx        = idx_q;
endmodule

// File: rtl/vseq_mem_sequencer.sv
`timescale 1ns/1ps
module vseq_mem_sequencer
    import vseq_pkg::*;
#(
    parameter  int unsigned NUM_ELEM = 32,
    parameter  int unsigned NUM_REGS = 32,
    localparam int unsigned IDX_W    = $clog2(NUM_ELEM),
    localparam int unsigned VL_W     = $clog2(NUM_ELEM + 1),
    localparam int unsigned REG_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_store,
    input  logic             cmd_strided,
    input  logic [1:0]       cmd_size,
    input  logic             cmd_zext,
    input  logic [XLEN-1:0]  cmd_base,
    input  logic [XLEN-1:0]  cmd_stride,
    input  logic [VL_W-1:0]  cmd_vlen,
    input  logic [REG_W-1:0] cmd_reg,
    input  logic             wide_int_en,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_write,
    output logic [1:0]       mem_req_size,
    output logic [XLEN-1:0]  mem_req_addr,
    output logic [XLEN-1:0]  mem_req_wdata,
    input  logic             mem_resp_valid,
    input  logic [XLEN-1:0]  mem_resp_data,
    output logic [REG_W-1:0] vreg_rd_reg,
    output logic [IDX_W-1:0] vreg_rd_elem,
    input  logic [XLEN-1:0]  vreg_rd_data,
    output logic             vreg_wr_en,
    output logic [REG_W-1:0] vreg_wr_reg,
    output logic [IDX_W-1:0] vreg_wr_elem,
    output logic [XLEN-1:0]  vreg_wr_data
);
    logic             accept, advance, resp_take, store_mode;
    logic [IDX_W-1:0] idx;
    logic [XLEN-1:0]  step_in;
    esize_e           size_q;
    logic             zext_q;
    logic [REG_W-1:0] reg_q;

    assign step_in = cmd_strided ? cmd_stride : size_bytes(esize_e'(cmd_size));

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q <= SZ_B;
            zext_q <= 1'b0;
            reg_q  <= '0;
        end else if (accept) begin
            size_q <= esize_e'(cmd_size);
            zext_q <= cmd_zext;
            reg_q  <= cmd_reg;
        end
    end

    vseq_ctrl #(.NUM_ELEM(NUM_ELEM)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_store   (cmd_store),
        .cmd_size    (cmd_size),
        .cmd_vlen    (cmd_vlen),
        .wide_int_en (wide_int_en),
        .req_ready   (mem_req_ready),
        .resp_valid  (mem_resp_valid),
        .accept      (accept),
        .busy        (busy),
        .done        (done),
        .illegal     (illegal),
        .req_valid   (mem_req_valid),
        .resp_take   (resp_take),
        .advance     (advance),
        .store_mode  (store_mode),
        .idx         (idx)
    );

    vseq_addr_gen addr_i (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .base    (cmd_base),
        .step    (step_in),
        .advance (advance),
        .addr    (mem_req_addr)
    );

    vseq_data_fmt fmt_i (
        .size       (size_q),
        .zext       (zext_q),
        .resp_data  (mem_resp_data),
        .slot_data  (vreg_rd_data),
        .load_data  (vreg_wr_data),
        .store_data (mem_req_wdata)
    );

    assign mem_req_write = store_mode;
    assign mem_req_size  = size_q;
    assign vreg_rd_reg   = reg_q;
    assign vreg_rd_elem  = idx;
    assign vreg_wr_en    = resp_take;
    assign vreg_wr_reg   = reg_q;
    assign vreg_wr_elem  = idx;
endmodule

// File: rtl/vseq_checker.sv
`timescale 1ns/1ps
module vseq_checker
    import vseq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            done,
    input logic            illegal,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic            mem_req_write,
    input logic [XLEN-1:0] mem_req_addr,
    input logic            vreg_wr_en
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R8

    AST_ONE_LOAD_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_ready && !mem_req_write |=> !mem_req_valid); // R8

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy && !done); // R9

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> busy); // R9

    AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !busy && !mem_req_valid); // R7

    AST_WRITE_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
        vreg_wr_en |-> busy && !mem_req_valid && !done); // R5
endmodule

bind vseq_mem_sequencer vseq_checker chk_i (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .done          (done),
    .illegal       (illegal),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .vreg_wr_en    (vreg_wr_en)
);

// File: tb/vseq_mem_sequencer_tb_top.sv
`timescale 1ns/1ps
module vseq_mem_sequencer_tb_top;
    localparam int unsigned NE    = 8;
    localparam int unsigned NR    = 32;
    localparam int unsigned IDX_W = $clog2(NE);
    localparam int unsigned VL_W  = $clog2(NE + 1);
    localparam int unsigned REG_W = $clog2(NR);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic             cmd_valid = 0, cmd_store = 0, cmd_strided = 0, cmd_zext = 0;
    logic [1:0]       cmd_size = 0;
    logic [63:0]      cmd_base = 0, cmd_stride = 0;
    logic [VL_W-1:0]  cmd_vlen = 0;
    logic [REG_W-1:0] cmd_reg = 0;
    logic             wide_int_en = 1;
    logic             busy, done, illegal;
    logic             mem_req_valid, mem_req_write;
    logic             mem_req_ready = 0;
    logic [1:0]       mem_req_size;
    logic [63:0]      mem_req_addr, mem_req_wdata;
    logic             mem_resp_valid = 0;
    logic [63:0]      mem_resp_data = 0;
    logic [REG_W-1:0] vreg_rd_reg, vreg_wr_reg;
    logic [IDX_W-1:0] vreg_rd_elem, vreg_wr_elem;
    logic [63:0]      vreg_rd_data, vreg_wr_data;
    logic             vreg_wr_en;

    logic [63:0] rf [NR][NE];
    assign vreg_rd_data = rf[vreg_rd_reg][vreg_rd_elem];

    int n_chk = 0;
    int n_fail = 0;

    vseq_mem_sequencer #(.NUM_ELEM(NE), .NUM_REGS(NR)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mdat(input logic [63:0] a);
        return {~a[31:0] ^ 32'h3C1F_0A77, a[31:0] ^ 32'h8E5A_96F1};
    endfunction

    function automatic logic [63:0] ext_exp(input logic [1:0] sz, input bit z,
                                            input logic [63:0] d);
        case (sz)
            2'd0: return z ? {56'd0, d[7:0]}  : {{56{d[7]}},  d[7:0]};
            2'd1: return z ? {48'd0, d[15:0]} : {{48{d[15]}}, d[15:0]};
            2'd2: return z ? {32'd0, d[31:0]} : {{32{d[31]}}, d[31:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [63:0] trim_exp(input logic [1:0] sz, input logic [63:0] d);
        case (sz)
            2'd0: return {56'd0, d[7:0]};
            2'd1: return {48'd0, d[15:0]};
            2'd2: return {32'd0, d[31:0]};
            default: return d;
        endcase
    endfunction

    // one full command, checked element by element
    task automatic run_cmd(input bit st, input bit strd, input logic [1:0] sz,
                           input bit z, input logic [63:0] base, input logic [63:0] stride,
                           input int vl, input int rg, input bit junk);
        int          vexp = (vl > NE) ? NE : vl;
        logic [63:0] inc  = strd ? stride : (64'd1 << sz);
        int          elem = 0;
        bit          pending = 0;
        int          delay = 0;
        logic [63:0] paddr = 0;
        bit          fin = 0;
        int          guard = 0;
        @(posedge clk); #1;
        cmd_valid = 1; cmd_store = st; cmd_strided = strd; cmd_size = sz; cmd_zext = z;
        cmd_base = base; cmd_stride = stride; cmd_vlen = VL_W'(vl); cmd_reg = REG_W'(rg);
        @(negedge clk);
        chk(busy == 0, "R9", "idle before accept", 64'(busy), 0);
        @(posedge clk); #1;
        cmd_valid = junk;
        if (junk) begin
            cmd_store = ~st; cmd_base = ~base; cmd_vlen = VL_W'(1); cmd_reg = ~cmd_reg;
        end
        while (!fin && guard < 400) begin
            guard++;
            @(negedge clk);
            chk(busy == 1, "R9", "busy during command", 64'(busy), 1);
            if (mem_resp_valid) begin
                if (pending) begin
                    chk(vreg_wr_en == 1, "R5", "write on response", 64'(vreg_wr_en), 1);
                    chk(vreg_wr_reg == REG_W'(rg) && vreg_wr_elem == IDX_W'(elem), "R5",
                        "write slot", {vreg_wr_reg, vreg_wr_elem}, {REG_W'(rg), IDX_W'(elem)});
                    chk(vreg_wr_data == ext_exp(sz, z, mdat(paddr)), "R5", "extended data",
                        vreg_wr_data, ext_exp(sz, z, mdat(paddr)));
                    rf[rg][elem] = vreg_wr_data;
                    elem++;
                    pending = 0;
                end else begin
                    chk(vreg_wr_en == 0, "R10", "stray response ignored", 64'(vreg_wr_en), 0);
                end
            end else begin
                chk(vreg_wr_en == 0, "R10", "no write without response", 64'(vreg_wr_en), 0);
            end
            if (mem_req_valid) begin
                chk(!pending, "R8", "request while load outstanding", 64'(pending), 0);
                chk(elem < vexp, "R4", "request beyond length", 64'(elem), 64'(vexp));
                chk(mem_req_addr == base + 64'(elem) * inc, strd ? "R3" : "R2",
                    "element address (R1)", mem_req_addr, base + 64'(elem) * inc);
                chk(mem_req_write == st && mem_req_size == sz, "R6", "direction/size",
                    {mem_req_write, mem_req_size}, {st, sz});
                if (st)
                    chk(mem_req_wdata == trim_exp(sz, rf[rg][elem]), "R6", "store data",
                        mem_req_wdata, trim_exp(sz, rf[rg][elem]));
                if (mem_req_ready) begin
                    if (st) elem++;
                    else begin
                        pending = 1; paddr = mem_req_addr; delay = $urandom % 3;
                    end
                end
            end
            if (done) begin
                chk(elem == vexp && !pending, "R4", "elements at done", 64'(elem), 64'(vexp));
                fin = 1;
            end
            @(posedge clk); #1;
            mem_resp_valid = 0;
            mem_resp_data  = {$urandom, $urandom};
            if (pending) begin
                if (delay == 0) begin
                    mem_resp_valid = 1; mem_resp_data = mdat(paddr);
                end else delay--;
            end else if (($urandom % 4) == 0) begin
                mem_resp_valid = 1;
            end
            mem_req_ready = ($urandom % 4) != 0;
        end
        cmd_valid = 0; mem_resp_valid = 0;
        if (!fin) chk(0, "R4", "command never finished", 0, 1);
        @(negedge clk);
        chk(busy == 0 && done == 0, "R9", "single done then idle", {busy, done}, 0);
    endtask

    task automatic refuse_cmd(input int rg);
        @(posedge clk); #1;
        wide_int_en = 0; cmd_valid = 1; cmd_store = 0; cmd_size = 2'd3;
        cmd_vlen = VL_W'(4); cmd_reg = REG_W'(rg); cmd_base = 64'h1000;
        @(posedge clk); #1;
        cmd_valid = 0;
        @(negedge clk);
        chk(illegal == 1, "R7", "illegal pulse", 64'(illegal), 1);
        chk(busy == 0 && mem_req_valid == 0, "R7", "no activity", {busy, mem_req_valid}, 0);
        @(negedge clk);
        chk(illegal == 0 && busy == 0 && mem_req_valid == 0, "R7", "pulse ends",
            {illegal, busy, mem_req_valid}, 0);
        @(posedge clk); #1;
        wide_int_en = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int r = 0; r < NR; r++)
            for (int e = 0; e < NE; e++)
                rf[r][e] = {$urandom, $urandom};
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && illegal == 0 && mem_req_valid == 0 && vreg_wr_en == 0,
            "R9", "reset state", {busy, done, illegal, mem_req_valid, vreg_wr_en}, 0);

        // R5: every size, signed and unsigned loads, unit stride
        for (int s = 0; s < 4; s++) begin
            run_cmd(0, 0, 2'(s), 0, 64'h0000_0000_8000_0F00, 0, 5, 3, 0);
            run_cmd(0, 0, 2'(s), 1, 64'h0000_0000_8000_0F81, 0, 5, 4, 0);
        end
        // R6: stores of every size, unit and strided
        for (int s = 0; s < 4; s++) begin
            run_cmd(1, 0, 2'(s), 0, 64'h2000, 0, 6, 7, 0);
            run_cmd(1, 1, 2'(s), 0, 64'h3000, 64'd40, 6, 9, 0);
        end
        // R1 wraparound, R3 negative and zero stride
        run_cmd(0, 1, 2'd2, 0, 64'hFFFF_FFFF_FFFF_FFF0, 64'd16, 8, 10, 0);
        run_cmd(1, 1, 2'd1, 0, 64'h0000_0000_0000_0010, -64'sd24, 7, 11, 0);
        run_cmd(0, 1, 2'd0, 0, 64'hABCD_0000_1234_5677, 64'd0, 6, 12, 0);
        run_cmd(1, 1, 2'd3, 0, 64'h5555_0000, 64'd0, 4, 13, 0);
        // R4: zero length, full length, clamped length
        run_cmd(0, 0, 2'd1, 0, 64'h4000, 0, 0, 14, 0);
        run_cmd(1, 0, 2'd2, 0, 64'h4000, 0, 0, 14, 0);
        run_cmd(0, 0, 2'd3, 0, 64'h5000, 0, NE, 15, 0);
        run_cmd(1, 0, 2'd0, 0, 64'h6000, 0, 15, 16, 0);
        // R7: refused doubleword, then a narrow load with wide mode off still runs
        refuse_cmd(17);
        @(posedge clk); #1 wide_int_en = 0;
        run_cmd(0, 0, 2'd2, 0, 64'h7000, 0, 3, 18, 0);
        @(posedge clk); #1 wide_int_en = 1;
        // R9: command input held with other values while busy
        run_cmd(0, 1, 2'd1, 1, 64'h9000, 64'd6, 5, 19, 1);
        run_cmd(1, 0, 2'd2, 0, 64'hA000, 0, 4, 20, 1);
        // constrained random mix
        for (int k = 0; k < 60; k++) begin
            int pick = $urandom % 4;
            logic [63:0] st = (pick == 0) ? 64'd0 :
                              (pick == 1) ? {{54{1'b0}}, 10'($urandom)} :
                              (pick == 2) ? -{{56{1'b0}}, 8'($urandom)} : {$urandom, $urandom};
            run_cmd(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                    {$urandom, $urandom}, st, $urandom % (NE + 3), $urandom % NR, 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule